// File: doc/BRIEF.md
# Cursor and Border Color Register Port

This block gives a byte-wide microprocessor bus access to three 24-bit color registers: a border (overscan) color and two cursor colors. An address register and three component holding registers stand between the bus and the color registers. Software writes a color as three byte cycles, red then green then blue, on the color data select. After the blue byte the three bytes are stored together as one 24-bit word, and the address steps to the next location. A run of locations can be loaded by giving one start address and then sending triplets back to back.

Reads work the other way round. Loading the address through the read-load select copies the whole addressed word into the holding registers at once. The bus then takes that word one component at a time. Each blue read fetches the next word in advance. A mode input selects 8-bit or 6-bit components on the bus.

Top module: `cursor_color_port`

## Requirements
- R1: On the data select (code 1), writes are taken in the order red, green, blue. No color register changes on the red or the green write of a triplet.
- R2: On the blue write, the word {red, green, blue} is stored at the location in the address register, with red in bits 23:16 and blue in bits 7:0.
- R3: After each completed write or read triplet, the 8-bit address register increments and wraps from 255 to 0.
- R4: The low two address bits pick the location: 00 is the border color, 01 is cursor color 0 and 10 is cursor color 1.
- R5: Location 11 holds no register. Triplets written to it are dropped, and words fetched from it read as zero.
- R6: A write on the read-load select (code 3) stores the written value plus one in the address register. It also copies the word at the location given by the written value into the holding registers, so the next data reads return that word.
- R7: A blue read on the data select fetches the word at the current address into the holding registers and increments the address.
- R8: With mode8_i high, each component byte passes unchanged, with D7 as the MSB.
- R9: With mode8_i low, a written byte is stored as {D5..D0, 00}. A read returns {00, component bits 7..2}, so D7 and D6 read as zero.
- R10: A write on either address select resets the component order to red.
- R11: A write on the write-load select (code 0) sets the address without fetching anything. A read on code 0 or code 3 returns the address and has no side effect. Code 2 is unused: writes to it are ignored and reads of it return zero.
- R12: After reset all color registers, holding registers and the address are zero, and the order starts at red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Register select code |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte; a write strobe in the same cycle takes priority |
| wdata_i | input | 8 | Write data |
| mode8_i | input | 1 | 1 selects 8-bit components, 0 selects 6-bit components |
| rdata_o | output | 8 | Read data for the current select |
| overscan_o | output | 24 | Border color |
| cursor0_o | output | 24 | Cursor color 0 |
| cursor1_o | output | 24 | Cursor color 1 |

## Verification
The assertions check the following on every cycle:
- the address increments and the order returns to red at the end of each triplet;
- any address load puts the order back to red;
- a read-load stores the written value plus one;
- no color register moves without a commit, and none moves on a commit to location 11;
- a prefetch lands in the holding registers;
- the top two read bits are zero in 6-bit mode.

Only the bench's scenarios show the rest:
- the full word layout and the location decode;
- that a triplet stored after a mid-triplet address reload contains only the new bytes;
- that the prefetch chain across consecutive locations returns the right bytes;
- that address wrap and the unused select leave everything else untouched.

The bench sweeps both bus modes over every location.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int SEL_W  = 2;
  localparam int COMP_W = 8;
  localparam int WORD_W = 3 * COMP_W;

  localparam logic [SEL_W-1:0] SEL_ADDR_WR = 2'd0;
  localparam logic [SEL_W-1:0] SEL_DATA    = 2'd1;
  localparam logic [SEL_W-1:0] SEL_UNUSED  = 2'd2;
  localparam logic [SEL_W-1:0] SEL_ADDR_RD = 2'd3;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_e;

  typedef logic [COMP_W-1:0] comp_t;

  typedef struct packed {
    comp_t r;
    comp_t g;
    comp_t b;
  } rgb_t;
endpackage

// File: rtl/ccp_seq.sv
module ccp_seq
  import ccp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_wr_i,
  input  logic              ld_rd_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] ld_val_i,
  output logic [ADDR_W-1:0] addr_o,
  output phase_e            phase_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] addr_q;
  phase_e            phase_q;

  assign last_o  = adv_i && (phase_q == PH_BLUE);
  assign addr_o  = addr_q;
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      phase_q <= PH_RED;
    end else if (ld_wr_i) begin
      addr_q  <= ld_val_i;
      phase_q <= PH_RED;
    end else if (ld_rd_i) begin
      addr_q  <= ld_val_i + ADDR_ONE;
      phase_q <= PH_RED;
    end else if (adv_i) begin
      unique case (phase_q)
        PH_RED:   phase_q <= PH_GREEN;
        PH_GREEN: phase_q <= PH_BLUE;
        default: begin
          phase_q <= PH_RED;
          addr_q  <= addr_q + ADDR_ONE;
        end
      endcase
    end
  end

  AST_TRIPLET_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !ld_wr_i && !ld_rd_i) |=> (addr_q == $past(addr_q) + ADDR_ONE) && (phase_q == PH_RED)); // R3
  AST_LOAD_TO_RED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_wr_i || ld_rd_i) |=> (phase_q == PH_RED)); // R10
  AST_RDLOAD_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_rd_i && !ld_wr_i) |=> (addr_q == $past(ld_val_i) + ADDR_ONE)); // R6
endmodule

// File: rtl/ccp_store.sv
module ccp_store
  import ccp_pkg::*;
#(
  parameter int LOC_N = 3,
  parameter int LOC_W = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          commit_i,
  input  logic [LOC_W-1:0]              commit_loc_i,
  input  rgb_t                          commit_word_i,
  input  logic [LOC_W-1:0]              rd_loc_i,
  output rgb_t                          rd_word_o,
  output logic [LOC_N-1:0][WORD_W-1:0]  colors_o
);
  logic [LOC_N-1:0][WORD_W-1:0] colors_q;

  for (genvar i = 0; i < LOC_N; i++) begin : g_loc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) colors_q[i] <= '0;
      else if (commit_i && (commit_loc_i == LOC_W'(i))) colors_q[i] <= commit_word_i;
    end
  end

  // locations at or above LOC_N read as zero
  always_comb begin
    rd_word_o = '0;
    for (int i = 0; i < LOC_N; i++)
      if (rd_loc_i == LOC_W'(i)) rd_word_o = colors_q[i];
  end

  assign colors_o = colors_q;

  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(colors_q)); // R1
  AST_UNUSED_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && (int'(commit_loc_i) >= LOC_N)) |=> $stable(colors_q)); // R5
endmodule

// File: rtl/ccp_hold.sv
module ccp_hold
  import ccp_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  rgb_t   load_word_i,
  input  logic   we_i,
  input  phase_e phase_i,
  input  comp_t  comp_i,
  output rgb_t   hold_o
);
  rgb_t hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
    end else if (load_i) begin
      hold_q <= load_word_i;
    end else if (we_i) begin
      unique case (phase_i)
        PH_RED:   hold_q.r <= comp_i;
        PH_GREEN: hold_q.g <= comp_i;
        default:  hold_q.b <= comp_i;
      endcase
    end
  end

  assign hold_o = hold_q;

  AST_PREFETCH_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (hold_q == $past(load_word_i))); // R7
endmodule

// File: rtl/ccp_bus_fmt.sv
module ccp_bus_fmt
  import ccp_pkg::*;
#(
  parameter int NARROW_W = 6
) (
  input  logic   mode8_i,
  input  comp_t  wdata_i,
  input  rgb_t   hold_i,
  input  phase_e phase_i,
  output comp_t  comp_in_o,
  output comp_t  comp_out_o
);
  localparam int PAD_W = COMP_W - NARROW_W;

  comp_t cur;

  always_comb begin
    unique case (phase_i)
      PH_RED:   cur = hold_i.r;
      PH_GREEN: cur = hold_i.g;
      default:  cur = hold_i.b;
    endcase
  end

  // narrow components are kept MSB-aligned in storage
  assign comp_in_o  = mode8_i ? wdata_i : {wdata_i[NARROW_W-1:0], {PAD_W{1'b0}}};
  assign comp_out_o = mode8_i ? cur : {{PAD_W{1'b0}}, cur[COMP_W-1 -: NARROW_W]};
endmodule

// File: rtl/cursor_color_port.sv
module cursor_color_port
  import ccp_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int LOC_N    = 3,
  parameter int NARROW_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [COMP_W-1:0] wdata_i,
  input  logic              mode8_i,
  output logic [COMP_W-1:0] rdata_o,
  output logic [WORD_W-1:0] overscan_o,
  output logic [WORD_W-1:0] cursor0_o,
  output logic [WORD_W-1:0] cursor1_o
);
  localparam int LOC_W = $clog2(LOC_N + 1);

  logic                         wr_ev, rd_ev, is_data;
  logic                         ld_wr, ld_rd, adv, last;
  logic [ADDR_W-1:0]            addr;
  phase_e                       phase;
  rgb_t                         hold, rd_word, commit_word;
  comp_t                        comp_in, comp_out;
  logic [LOC_W-1:0]             rd_loc;
  logic [LOC_N-1:0][WORD_W-1:0] colors;

  assign wr_ev   = wr_i;
  assign rd_ev   = rd_i && !wr_i;
  assign is_data = (sel_i == SEL_DATA);
  assign ld_wr   = wr_ev && (sel_i == SEL_ADDR_WR);
  assign ld_rd   = wr_ev && (sel_i == SEL_ADDR_RD);
  assign adv     = (wr_ev || rd_ev) && is_data;

  ccp_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_wr_i  (ld_wr),
    .ld_rd_i  (ld_rd),
    .adv_i    (adv),
    .ld_val_i (ADDR_W'(wdata_i)),
    .addr_o   (addr),
    .phase_o  (phase),
    .last_o   (last)
  );

  ccp_bus_fmt #(.NARROW_W(NARROW_W)) u_fmt (
    .mode8_i    (mode8_i),
    .wdata_i    (wdata_i),
    .hold_i     (hold),
    .phase_i    (phase),
    .comp_in_o  (comp_in),
    .comp_out_o (comp_out)
  );

  assign commit_word = '{r: hold.r, g: hold.g, b: comp_in};
  assign rd_loc      = ld_rd ? wdata_i[LOC_W-1:0] : addr[LOC_W-1:0];

  ccp_store #(.LOC_N(LOC_N), .LOC_W(LOC_W)) u_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .commit_i      (wr_ev && last),
    .commit_loc_i  (addr[LOC_W-1:0]),
    .commit_word_i (commit_word),
    .rd_loc_i      (rd_loc),
    .rd_word_o     (rd_word),
    .colors_o      (colors)
  );

  ccp_hold u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (ld_rd || (rd_ev && last)),
    .load_word_i (rd_word),
    .we_i        (wr_ev && is_data),
    .phase_i     (phase),
    .comp_i      (comp_in),
    .hold_o      (hold)
  );

  always_comb begin
    unique case (sel_i)
      SEL_DATA:                 rdata_o = comp_out;
      SEL_ADDR_WR, SEL_ADDR_RD: rdata_o = COMP_W'(addr);
      default:                  rdata_o = '0;
    endcase
  end

  assign overscan_o = colors[0];
  assign cursor0_o  = colors[1];
  assign cursor1_o  = colors[2];

  AST_NARROW_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode8_i && (sel_i == SEL_DATA)) |-> (rdata_o[COMP_W-1:NARROW_W] == '0)); // R9
  AST_UNUSED_SEL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_UNUSED) |-> (rdata_o == '0)); // R11
endmodule

// File: tb/sim_cursor_color_port.sv
module sim_cursor_color_port;
  logic        clk = 0;
  logic        rst_ni = 0;
  logic [1:0]  sel = 0;
  logic        wr = 0, rd = 0, mode8 = 1;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic [23:0] ovs, cur0, cur1;

  int checks = 0, errors = 0;
  logic [23:0] m_col [4];
  logic [7:0]  m_addr;
  logic [23:0] m_hold;

  always #4 clk = ~clk;

  cursor_color_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .mode8_i(mode8), .rdata_o(rdata),
    .overscan_o(ovs), .cursor0_o(cur0), .cursor1_o(cur1)
  );

  function automatic logic [7:0] exp_w(input logic [7:0] d, input logic m8);
    return m8 ? d : {d[5:0], 2'b00};
  endfunction

  function automatic logic [7:0] exp_r(input logic [7:0] c, input logic m8);
    return m8 ? c : {2'b00, c[7:2]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_b(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); sel = s; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_b(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk); sel = s; rd = 1;
    #1 v = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic chk_cols(input string req);
    chk({req, " overscan"}, ovs, m_col[0]);
    chk({req, " cursor0"}, cur0, m_col[1]);
    chk({req, " cursor1"}, cur1, m_col[2]);
  endtask

  // write one triplet; model commit and address step
  task automatic triplet(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    wr_b(2'd1, r);
    wr_b(2'd1, g);
    chk_cols("R1 before blue");
    wr_b(2'd1, b);
    if (m_addr[1:0] != 2'b11)
      m_col[m_addr[1:0]] = {exp_w(r, mode8), exp_w(g, mode8), exp_w(b, mode8)};
    m_addr = m_addr + 8'd1;
  endtask

  initial begin
    logic [7:0] v;
    string rq;
    for (int i = 0; i < 4; i++) m_col[i] = '0;
    m_addr = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    chk_cols("R12 reset");
    rd_b(2'd0, v); chk("R12 reset addr", v, 0);

    // write sweep, both modes, starts over all locations
    for (int m = 1; m >= 0; m--) begin
      mode8 = m[0];
      rq = m ? "R8" : "R9";
      for (int k = 0; k < 6; k++) begin
        wr_b(2'd0, 8'(k)); m_addr = 8'(k);
        for (int t = 0; t < 2; t++) begin
          triplet(8'(k * 29 + t * 7 + m * 101 + 3), 8'(k * 53 + t * 91 + 200), 8'(255 - k * 17 - t * 5 - m));
          chk_cols({"R2 R4 R5 ", rq});
          rd_b(2'd0, v); chk("R3 addr after triplet", v, m_addr);
        end
      end
    end
    mode8 = 1;

    // wrap from 255 onto unused location
    wr_b(2'd0, 8'hFF); m_addr = 8'hFF;
    triplet(8'h12, 8'h34, 8'h56);
    chk_cols("R5 unused dropped");
    rd_b(2'd3, v); chk("R3 wrap", v, 8'h00);

    // address reload mid-triplet restarts at red
    wr_b(2'd0, 8'd1);
    wr_b(2'd1, 8'hAA);
    wr_b(2'd1, 8'hBB);
    wr_b(2'd0, 8'd2); m_addr = 8'd2;
    triplet(8'h11, 8'h22, 8'h33);
    chk_cols("R10 reload to red");
    chk("R10 cursor1 word", cur1, 24'h112233);

    // read sweep with prefetch chain
    for (int m = 1; m >= 0; m--) begin
      mode8 = m[0];
      rq = m ? "R8" : "R9";
      for (int s = 0; s < 4; s++) begin
        wr_b(2'd3, 8'(s));
        m_hold = m_col[s]; m_addr = 8'(s + 1);
        for (int t = 0; t < 2; t++) begin
          rd_b(2'd1, v); chk({"R6 R7 red ", rq}, v, exp_r(m_hold[23:16], mode8));
          rd_b(2'd1, v); chk({"R6 R7 green ", rq}, v, exp_r(m_hold[15:8], mode8));
          rd_b(2'd1, v); chk({"R6 R7 blue ", rq}, v, exp_r(m_hold[7:0], mode8));
          m_hold = m_col[m_addr[1:0]];
          m_addr = m_addr + 8'd1;
        end
        rd_b(2'd0, v); chk("R3 addr after reads", v, m_addr);
      end
    end
    mode8 = 1;
    chk_cols("R6 reads leave colors");

    // write-load does not prefetch: holding keeps last prefetch
    wr_b(2'd0, 8'd0);
    rd_b(2'd1, v); chk("R11 write-load no fetch", v, m_hold[23:16]);

    // unused select
    wr_b(2'd0, 8'd5); m_addr = 8'd5;
    wr_b(2'd2, 8'h5A);
    rd_b(2'd2, v); chk("R11 unused select reads zero", v, 0);
    rd_b(2'd0, v); chk("R11 addr untouched", v, 8'd5);
    rd_b(2'd3, v); chk("R11 addr read no side effect", v, 8'd5);
    chk_cols("R11 unused write ignored");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule